// File: doc/BRIEF.md
# ARP request responder

This block sits beside an Ethernet receive path and answers address-resolution requests that ask for the local IPv4 address. Frames arrive as 64-bit stream beats. The first byte on the wire is carried in bits 7:0 of each beat. The block reads the fixed header of each frame one beat at a time. It checks the protocol fields and compares the requested address with the configured one. When the frame qualifies, it sends one complete 64-byte reply frame on a 64-bit transmit stream.

Both stream edges use valid/ready handshakes.

- **Receive side:** a beat transfers on a clock edge where `s_axis_tvalid` and `s_axis_tready` are both high. The source may drop valid between beats for any number of cycles. The block lowers ready in two situations: for one cycle after each frame ends, while that frame is judged, and for the whole time a reply is being sent.
- **Transmit side:** once valid is raised, the reply beat is held unchanged until the sink accepts it with ready. The sink may stall for any number of cycles.

The local MAC and IP addresses are static configuration inputs. Traffic that is not an ARP request is consumed and not forwarded.

Top module: `arp_reply_engine`

## Requirements
- R1: After reset the transmit side shows no valid beat and the receive side is ready.
- R2: Wire byte n of a frame is lane n mod 8 of beat n div 8, held in bits 8*lane+7 to 8*lane. Multi-byte fields are big-endian on the wire. The byte offsets are: destination 0, source 6, type 12, hardware type 14, protocol type 16, hardware length 18, protocol length 19, operation 20, sender MAC 22, sender IP 28, target MAC 32, target IP 38.
- R3: A frame is only considered when all six of these fields match: type 0x0806, hardware type 0x0001, protocol type 0x0800, hardware length 6, protocol length 4 and operation 0x0001. Any other frame produces no reply.
- R4: A reply is produced only when the target IP equals `local_ip`. Requests for any other address are dropped silently.
- R5: The reply carries the requester's sender MAC in its destination and target-MAC fields, and `local_mac` in its source and sender-MAC fields. Its sender IP is `local_ip` and its target IP is the requester's sender IP. The operation field is 0x0002. Type 0x0806 and the four type/length fields are copied from the request. Bytes 42 to 63 are zero.
- R6: A reply is exactly 8 beats. Every beat has tkeep 0xFF and tuser 0, and tlast is set on the eighth beat only. Valid drops after the eighth beat is accepted.
- R7: While a reply beat is valid and not accepted, valid stays high and data and tlast do not change.
- R8: Requests whose beats are separated by idle cycles are answered the same way as back-to-back beats.
- R9: A frame with tuser high on any beat, including beats after the header, gets no reply even if every field matches.
- R10: A frame is discarded as short if it ends with tlast before its sixth beat, or if a header beat lacks tkeep lanes that carry header bytes. Beats 0 to 4 need all lanes; beat 5 needs lanes 0 and 1. The next frame is parsed from its first byte.
- R11: `s_axis_tready` is low in the cycle after a frame's last beat is accepted and for every cycle a reply beat is valid. It is high again once the reply's last beat is accepted, or one cycle after a dropped frame ends.
- R12: Beats after the header, up to tlast, are consumed and ignored, so longer frames are still answered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Synchronous reset, active low |
| local_mac | input | 48 | Local MAC address, first wire byte in bits 47:40 |
| local_ip | input | 32 | Local IPv4 address, first wire byte in bits 31:24 |
| s_axis_tdata | input | 64 | Receive beat data |
| s_axis_tkeep | input | 8 | Receive byte-lane enables |
| s_axis_tvalid | input | 1 | Receive beat valid |
| s_axis_tready | output | 1 | Receive beat ready |
| s_axis_tlast | input | 1 | Last beat of a receive frame |
| s_axis_tuser | input | 1 | Receive beat error flag |
| m_axis_tdata | output | 64 | Reply beat data |
| m_axis_tkeep | output | 8 | Reply byte-lane enables |
| m_axis_tvalid | output | 1 | Reply beat valid |
| m_axis_tready | input | 1 | Reply beat ready |
| m_axis_tlast | output | 1 | Last beat of the reply |
| m_axis_tuser | output | 1 | Reply error flag, always 0 |

## Verification
The bench builds the block with its default of 8 reply beats. The header takes a fixed 6 beats, so the frame lengths the bench sends straddle that boundary: 4-beat frames that end early, the 8-beat minimum, and 12-beat oversize frames. The sink accepts at several rates, from every cycle to one beat in eight. This exposes the hold behaviour across long stalls. It also shows that the receive side stays blocked for the whole reply.

// File: rtl/arp_reply_pkg.sv
package arp_reply_pkg;
  localparam int BYTE_W     = 8;
  localparam int BEAT_BYTES = 8;
  localparam int BEAT_W     = BEAT_BYTES * BYTE_W;
  localparam int HDR_BYTES  = 42;
  localparam int HDR_BEATS  = (HDR_BYTES + BEAT_BYTES - 1) / BEAT_BYTES;
  localparam int HDR_BITS   = HDR_BEATS * BEAT_W;
  localparam int TAIL_LANES = HDR_BYTES - (HDR_BEATS - 1) * BEAT_BYTES;

  // wire-byte offsets; the responder decodes fields at these positions
  localparam int OFF_DST   = 0;
  localparam int OFF_SRC   = 6;
  localparam int OFF_ETYPE = 12;
  localparam int OFF_HTYPE = 14;
  localparam int OFF_PTYPE = 16;
  localparam int OFF_HLEN  = 18;
  localparam int OFF_PLEN  = 19;
  localparam int OFF_OPER  = 20;
  localparam int OFF_SHA   = 22;
  localparam int OFF_SPA   = 28;
  localparam int OFF_THA   = 32;
  localparam int OFF_TPA   = 38;

  localparam logic [15:0] ETYPE_ARP  = 16'h0806;
  localparam logic [15:0] HTYPE_ETH  = 16'h0001;
  localparam logic [15:0] PTYPE_IP4  = 16'h0800;
  localparam logic [7:0]  HLEN_MAC   = 8'd6;
  localparam logic [7:0]  PLEN_IP4   = 8'd4;
  localparam logic [15:0] OPER_ASK   = 16'h0001;
  localparam logic [15:0] OPER_ANS   = 16'h0002;

  typedef struct packed {
    logic [47:0] sha;
    logic [31:0] spa;
    logic [15:0] htype;
    logic [15:0] ptype;
    logic [7:0]  hlen;
    logic [7:0]  plen;
  } arp_req_t;

  function automatic logic [7:0] hdr_byte(input logic [HDR_BITS-1:0] h, input int n);
    return h[BYTE_W*n +: BYTE_W];
  endfunction
endpackage

// File: rtl/arp_rx_parser.sv
module arp_rx_parser
  import arp_reply_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BEAT_W-1:0] s_data,
  input  logic [BEAT_BYTES-1:0] s_keep,
  input  logic              s_last,
  input  logic              s_user,
  input  logic [31:0]       local_ip,
  output logic              done,
  output logic              hit,
  output arp_req_t          req
);
  localparam int IDX_W = $clog2(HDR_BEATS + 1);

  logic [IDX_W-1:0]    beat_idx;
  logic [HDR_BITS-1:0] hdr;
  logic                err_q;
  logic                done_q;
  logic                long_q;
  logic                bad_q;
  logic                keep_ok;

  always_comb begin
    if (beat_idx < IDX_W'(HDR_BEATS - 1))
      keep_ok = &s_keep;
    else if (beat_idx == IDX_W'(HDR_BEATS - 1))
      keep_ok = &s_keep[TAIL_LANES-1:0];
    else
      keep_ok = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_idx <= '0;
      hdr      <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      long_q   <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        for (int b = 0; b < HDR_BEATS; b++)
          if (beat_idx == IDX_W'(b)) hdr[b*BEAT_W +: BEAT_W] <= s_data;
        if (s_last) begin
          beat_idx <= '0;
          err_q    <= 1'b0;
          done_q   <= 1'b1;
          long_q   <= (beat_idx >= IDX_W'(HDR_BEATS - 1));
          bad_q    <= err_q | s_user | ~keep_ok;
        end else begin
          if (beat_idx != IDX_W'(HDR_BEATS)) beat_idx <= beat_idx + 1'b1;
          err_q <= err_q | s_user | ~keep_ok;
        end
      end
    end
  end

  logic [15:0] f_etype, f_htype, f_ptype, f_oper;
  logic [7:0]  f_hlen, f_plen;
  logic [47:0] f_sha;
  logic [31:0] f_spa, f_tpa;

  always_comb begin
    f_etype = {hdr_byte(hdr, OFF_ETYPE), hdr_byte(hdr, OFF_ETYPE + 1)};
    f_htype = {hdr_byte(hdr, OFF_HTYPE), hdr_byte(hdr, OFF_HTYPE + 1)};
    f_ptype = {hdr_byte(hdr, OFF_PTYPE), hdr_byte(hdr, OFF_PTYPE + 1)};
    f_oper  = {hdr_byte(hdr, OFF_OPER),  hdr_byte(hdr, OFF_OPER + 1)};
    f_hlen  = hdr_byte(hdr, OFF_HLEN);
    f_plen  = hdr_byte(hdr, OFF_PLEN);
    f_sha   = {hdr_byte(hdr, OFF_SHA),     hdr_byte(hdr, OFF_SHA + 1),
               hdr_byte(hdr, OFF_SHA + 2), hdr_byte(hdr, OFF_SHA + 3),
               hdr_byte(hdr, OFF_SHA + 4), hdr_byte(hdr, OFF_SHA + 5)};
    f_spa   = {hdr_byte(hdr, OFF_SPA),     hdr_byte(hdr, OFF_SPA + 1),
               hdr_byte(hdr, OFF_SPA + 2), hdr_byte(hdr, OFF_SPA + 3)};
    f_tpa   = {hdr_byte(hdr, OFF_TPA),     hdr_byte(hdr, OFF_TPA + 1),
               hdr_byte(hdr, OFF_TPA + 2), hdr_byte(hdr, OFF_TPA + 3)};
  end

  logic fields_ok;
  assign fields_ok = (f_etype == ETYPE_ARP) && (f_htype == HTYPE_ETH) &&
                     (f_ptype == PTYPE_IP4) && (f_hlen == HLEN_MAC) &&
                     (f_plen == PLEN_IP4)   && (f_oper == OPER_ASK);

  assign done = done_q;
  assign hit  = done_q && long_q && !bad_q && fields_ok && (f_tpa == local_ip);

  always_comb begin
    req.sha   = f_sha;
    req.spa   = f_spa;
    req.htype = f_htype;
    req.ptype = f_ptype;
    req.hlen  = f_hlen;
    req.plen  = f_plen;
  end

  // R10: a frame end always restarts the header at beat 0
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take && s_last |=> (beat_idx == '0) && done_q);

  // R11: the judge cycle is a single pulse because intake is closed during it
  p_judge_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/arp_tx_builder.sv
module arp_tx_builder
  import arp_reply_pkg::*;
#(
  parameter int REPLY_BEATS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  arp_req_t              req,
  input  logic [47:0]           local_mac,
  input  logic [31:0]           local_ip,
  output logic [BEAT_W-1:0]     m_data,
  output logic [BEAT_BYTES-1:0] m_keep,
  output logic                  m_valid,
  input  logic                  m_ready,
  output logic                  m_last,
  output logic                  m_user,
  output logic                  busy
);
  localparam int REPLY_BITS = REPLY_BEATS * BEAT_W;
  localparam int IDX_W      = $clog2(REPLY_BEATS);

  arp_req_t         req_q;
  logic [47:0]      mac_q;
  logic [31:0]      ip_q;
  logic [IDX_W-1:0] idx;
  logic             active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      mac_q  <= '0;
      ip_q   <= '0;
      idx    <= '0;
      active <= 1'b0;
    end else if (!active) begin
      if (start) begin
        req_q  <= req;
        mac_q  <= local_mac;
        ip_q   <= local_ip;
        idx    <= '0;
        active <= 1'b1;
      end
    end else if (m_ready) begin
      if (idx == IDX_W'(REPLY_BEATS - 1)) active <= 1'b0;
      else idx <= idx + 1'b1;
    end
  end

  function automatic logic [REPLY_BITS-1:0] place(input logic [REPLY_BITS-1:0] v,
                                                  input int off, input int len,
                                                  input logic [47:0] val);
    for (int i = 0; i < 6; i++)
      if (i < len) v[BYTE_W*(off+i) +: BYTE_W] = val[BYTE_W*(len-1-i) +: BYTE_W];
    return v;
  endfunction

  logic [REPLY_BITS-1:0] frame;
  always_comb begin
    frame = '0;
    frame = place(frame, OFF_DST,   6, req_q.sha);
    frame = place(frame, OFF_SRC,   6, mac_q);
    frame = place(frame, OFF_ETYPE, 2, 48'(ETYPE_ARP));
    frame = place(frame, OFF_HTYPE, 2, 48'(req_q.htype));
    frame = place(frame, OFF_PTYPE, 2, 48'(req_q.ptype));
    frame = place(frame, OFF_HLEN,  1, 48'(req_q.hlen));
    frame = place(frame, OFF_PLEN,  1, 48'(req_q.plen));
    frame = place(frame, OFF_OPER,  2, 48'(OPER_ANS));
    frame = place(frame, OFF_SHA,   6, mac_q);
    frame = place(frame, OFF_SPA,   4, 48'(ip_q));
    frame = place(frame, OFF_THA,   6, req_q.sha);
    frame = place(frame, OFF_TPA,   4, 48'(req_q.spa));
  end

  assign m_data  = frame[idx*BEAT_W +: BEAT_W];
  assign m_keep  = '1;
  assign m_valid = active;
  assign m_last  = (idx == IDX_W'(REPLY_BEATS - 1));
  assign m_user  = 1'b0;
  assign busy    = active;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));

  p_full_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_keep == '1) && !m_user);

  p_one_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && m_last |=> !m_valid);
endmodule

// File: rtl/arp_reply_engine.sv
module arp_reply_engine
  import arp_reply_pkg::*;
#(
  parameter int REPLY_BEATS = 8
) (
  input  logic        aclk,
  input  logic        aresetn,
  input  logic [47:0] local_mac,
  input  logic [31:0] local_ip,
  input  logic [63:0] s_axis_tdata,
  input  logic [7:0]  s_axis_tkeep,
  input  logic        s_axis_tvalid,
  output logic        s_axis_tready,
  input  logic        s_axis_tlast,
  input  logic        s_axis_tuser,
  output logic [63:0] m_axis_tdata,
  output logic [7:0]  m_axis_tkeep,
  output logic        m_axis_tvalid,
  input  logic        m_axis_tready,
  output logic        m_axis_tlast,
  output logic        m_axis_tuser
);
  logic     judge;
  logic     hit;
  logic     tx_busy;
  logic     rx_ready;
  arp_req_t req;

  assign rx_ready      = !(judge || tx_busy);
  assign s_axis_tready = rx_ready;

  arp_rx_parser u_parser (
    .clk      (aclk),
    .rst_n    (aresetn),
    .take     (s_axis_tvalid && rx_ready),
    .s_data   (s_axis_tdata),
    .s_keep   (s_axis_tkeep),
    .s_last   (s_axis_tlast),
    .s_user   (s_axis_tuser),
    .local_ip (local_ip),
    .done     (judge),
    .hit      (hit),
    .req      (req)
  );

  arp_tx_builder #(.REPLY_BEATS(REPLY_BEATS)) u_builder (
    .clk       (aclk),
    .rst_n     (aresetn),
    .start     (hit),
    .req       (req),
    .local_mac (local_mac),
    .local_ip  (local_ip),
    .m_data    (m_axis_tdata),
    .m_keep    (m_axis_tkeep),
    .m_valid   (m_axis_tvalid),
    .m_ready   (m_axis_tready),
    .m_last    (m_axis_tlast),
    .m_user    (m_axis_tuser),
    .busy      (tx_busy)
  );

  // R11: no intake while a reply beat is on offer
  p_rx_blocked_r11: assert property (@(posedge aclk) disable iff (!aresetn)
    m_axis_tvalid |-> !s_axis_tready);
endmodule

// File: tb/arp_reply_engine_test.sv
module arp_reply_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] MY_MAC = 48'h02_11_22_33_44_55;
  localparam logic [31:0] MY_IP  = 32'hC0A8_0A05;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] s_data;
  logic [7:0]  s_keep;
  logic        s_valid, s_last, s_user;
  logic        s_ready;
  logic [63:0] m_data;
  logic [7:0]  m_keep;
  logic        m_valid, m_last, m_user;
  logic        m_ready;

  int checks = 0;
  int errors = 0;
  logic [7:0] fr [0:127];
  logic [7:0] exp_b [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  arp_reply_engine uut (
    .aclk(clk), .aresetn(rst_n), .local_mac(MY_MAC), .local_ip(MY_IP),
    .s_axis_tdata(s_data), .s_axis_tkeep(s_keep), .s_axis_tvalid(s_valid),
    .s_axis_tready(s_ready), .s_axis_tlast(s_last), .s_axis_tuser(s_user),
    .m_axis_tdata(m_data), .m_axis_tkeep(m_keep), .m_axis_tvalid(m_valid),
    .m_axis_tready(m_ready), .m_axis_tlast(m_last), .m_axis_tuser(m_user)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fr_put(input int off, input int len, input logic [47:0] val);
    for (int i = 0; i < len; i++) fr[off+i] = val[8*(len-1-i) +: 8];
  endtask

  task automatic exp_put(input int off, input int len, input logic [47:0] val);
    for (int i = 0; i < len; i++) exp_b[off+i] = val[8*(len-1-i) +: 8];
  endtask

  task automatic make_req(input logic [47:0] sha, input logic [31:0] spa, input logic [31:0] tpa,
                          input logic [15:0] oper, input logic [15:0] etype);
    for (int i = 0; i < 128; i++) fr[i] = 8'h00;
    fr_put(0, 6, 48'hFFFF_FFFF_FFFF);
    fr_put(6, 6, sha);
    fr_put(12, 2, 48'(etype));
    fr_put(14, 2, 48'h0001);
    fr_put(16, 2, 48'h0800);
    fr_put(18, 1, 48'h06);
    fr_put(19, 1, 48'h04);
    fr_put(20, 2, 48'(oper));
    fr_put(22, 6, sha);
    fr_put(28, 4, 48'(spa));
    fr_put(32, 6, 48'h0);
    fr_put(38, 4, 48'(tpa));
    for (int i = 42; i < 128; i++) fr[i] = 8'(i * 7);
  endtask

  task automatic make_exp(input logic [47:0] sha, input logic [31:0] spa);
    for (int i = 0; i < 64; i++) exp_b[i] = 8'h00;
    exp_put(0, 6, sha);
    exp_put(6, 6, MY_MAC);
    exp_put(12, 2, 48'h0806);
    exp_put(14, 2, 48'h0001);
    exp_put(16, 2, 48'h0800);
    exp_put(18, 1, 48'h06);
    exp_put(19, 1, 48'h04);
    exp_put(20, 2, 48'h0002);
    exp_put(22, 6, MY_MAC);
    exp_put(28, 4, 48'(MY_IP));
    exp_put(32, 6, sha);
    exp_put(38, 4, 48'(spa));
  endtask

  // starts and ends at a falling edge
  task automatic send_frame(input int nbeats, input int gap, input int user_beat, input int thin_beat);
    for (int b = 0; b < nbeats; b++) begin
      s_valid = 1'b1;
      for (int k = 0; k < 8; k++) s_data[8*k +: 8] = fr[8*b+k];
      s_keep = (b == thin_beat) ? 8'h0F : 8'hFF;
      s_last = (b == nbeats - 1);
      s_user = (b == user_beat);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      if (gap > 0) begin
        s_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    s_valid = 1'b0; s_last = 1'b0; s_user = 1'b0;
  endtask

  task automatic collect(input int every, input string tag);
    int got = 0;
    int cyc = 0;
    bit pend = 1'b0;
    bit stab_bad = 1'b0;
    bit rx_bad = 1'b0;
    logic [63:0] pd = '0;
    logic pl = 1'b0;
    logic [63:0] want;
    while (got < 8 && cyc < 600) begin
      if (m_valid) begin
        if (s_ready) rx_bad = 1'b1;
        if (pend && (m_data !== pd || m_last !== pl)) stab_bad = 1'b1;
        m_ready = ((cyc % every) == every - 1);
        if (m_ready) begin
          for (int k = 0; k < 8; k++) want[8*k +: 8] = exp_b[8*got+k];
          check(m_data === want, {"R2/R5 beat data ", tag}, m_data, want);
          check(m_keep === 8'hFF && m_user === 1'b0 && m_last === (got == 7),
                {"R6 keep/user/last ", tag}, {54'd0, m_keep, m_user, m_last},
                {54'd0, 8'hFF, 1'b0, 1'(got == 7)});
          got++;
          pend = 1'b0;
        end else begin
          pend = 1'b1; pd = m_data; pl = m_last;
        end
      end else begin
        if (pend) stab_bad = 1'b1;
        m_ready = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    m_ready = 1'b0;
    check(got == 8, {"R6 beat count ", tag}, 64'(got), 64'd8);
    check(!stab_bad, {"R7 hold under stall ", tag}, 64'(stab_bad), 64'd0);
    check(!rx_bad, {"R11 intake closed during reply ", tag}, 64'(rx_bad), 64'd0);
    check(m_valid === 1'b0, {"R6 valid drops after last ", tag}, 64'(m_valid), 64'd0);
    check(s_ready === 1'b1, {"R11 intake reopens ", tag}, 64'(s_ready), 64'd1);
  endtask

  task automatic expect_none(input int cycles, input string tag);
    bit seen = 1'b0;
    repeat (cycles) begin
      if (m_valid) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, {tag, " no reply"}, 64'(seen), 64'd0);
    check(s_ready === 1'b1, {"R11 ready after drop ", tag}, 64'(s_ready), 64'd1);
  endtask

  task automatic t_reset;
    check(m_valid === 1'b0, "R1 valid low after reset", 64'(m_valid), 64'd0);
    check(s_ready === 1'b1, "R1 ready high after reset", 64'(s_ready), 64'd1);
  endtask

  task automatic t_basic_gapped;
    make_req(48'h00D0_0D01_0101, 32'h0A01_0B02, MY_IP, 16'h0001, 16'h0806);
    make_exp(48'h00D0_0D01_0101, 32'h0A01_0B02);
    send_frame(8, 7, -1, -1);
    collect(8, "R8 gapped, slow sink");
  endtask

  task automatic t_other_ip;
    make_req(48'h0A0B_0C0D_0E0F, 32'h0A00_0001, 32'hC0A8_0A06, 16'h0001, 16'h0806);
    send_frame(8, 0, -1, -1);
    expect_none(30, "R4 other address");
  endtask

  task automatic t_bad_fields;
    make_req(48'h0A0B_0C0D_0E0F, 32'h0A00_0001, MY_IP, 16'h0002, 16'h0806);
    send_frame(8, 1, -1, -1);
    expect_none(30, "R3 operation 2");
    make_req(48'h0A0B_0C0D_0E0F, 32'h0A00_0001, MY_IP, 16'h0001, 16'h0800);
    send_frame(8, 0, -1, -1);
    expect_none(30, "R3 type 0x0800");
    make_req(48'h0A0B_0C0D_0E0F, 32'h0A00_0001, MY_IP, 16'h0001, 16'h0806);
    fr[18] = 8'h08;
    send_frame(8, 0, -1, -1);
    expect_none(30, "R3 hardware length 8");
  endtask

  task automatic t_errored;
    make_req(48'h1111_2222_3333, 32'h0A00_0002, MY_IP, 16'h0001, 16'h0806);
    send_frame(8, 2, 3, -1);
    expect_none(30, "R9 tuser in header");
    send_frame(8, 0, 7, -1);
    expect_none(30, "R9 tuser on last beat");
  endtask

  task automatic t_short_then_good;
    make_req(48'h4444_5555_6666, 32'h0A00_0003, MY_IP, 16'h0001, 16'h0806);
    send_frame(4, 0, -1, -1);
    expect_none(30, "R10 four-beat frame");
    send_frame(8, 0, -1, 2);
    expect_none(30, "R10 thin header beat");
    make_exp(48'h4444_5555_6666, 32'h0A00_0003);
    send_frame(8, 0, -1, -1);
    collect(1, "R10 resync");
  endtask

  task automatic t_oversize;
    make_req(48'h7777_8888_9999, 32'h0A00_0004, MY_IP, 16'h0001, 16'h0806);
    make_exp(48'h7777_8888_9999, 32'h0A00_0004);
    send_frame(12, 1, -1, -1);
    collect(3, "R12 twelve-beat request");
  endtask

  task automatic t_back_to_back;
    make_req(48'hAAAA_BBBB_CCCC, 32'hAC10_0001, MY_IP, 16'h0001, 16'h0806);
    make_exp(48'hAAAA_BBBB_CCCC, 32'hAC10_0001);
    send_frame(8, 0, -1, -1);
    collect(1, "R8 dense beats");
    make_req(48'h0102_0304_0506, 32'h0708_090A, MY_IP, 16'h0001, 16'h0806);
    make_exp(48'h0102_0304_0506, 32'h0708_090A);
    send_frame(8, 0, -1, -1);
    collect(2, "R2 second request");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; s_last = 1'b0; s_user = 1'b0;
    s_keep = 8'h00; s_data = '0; m_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_gapped();
    t_other_ip();
    t_bad_fields();
    t_errored();
    t_short_then_good();
    t_oversize();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule